// File: doc/BRIEF.md
# Instruction Fetch Address Translation Controller

This block turns the virtual address of an instruction fetch into a physical address. Each cycle that a request is presented, it classifies the fetch address. A privileged-code address, marked by its low bit, skips translation. An address outside the canonical range is rejected. An address in the kernel-only direct-mapped window is passed straight through. Every other address goes through the shared translation buffer: the block drives the page number and address-space identifier out to that buffer and takes back its hit flag, physical page number and per-mode execute-permission mask in the same cycle.

One cycle after a request, the block returns a registered response. The response carries a result code, the physical address and a flag that marks uncacheable space. A faulting fetch loads two capture registers, unless the request is flagged as misspeculated. One holds the faulting address. The other holds a formatted page-table-entry address, built from a page-table base and the virtual page number. Three event counters track hits, misses and access violations, and a fourth holds their access total.

Top module: `ifx_xlate`

## Requirements
- R1: When `reqPc[0]` is 1, the response is result none, the physical address is `reqPc[39:2]` followed by two zero bits, and `rspUncached` is 0. The other checks are not applied, so a non-canonical address with the low bit set still resolves this way.
- R2: When the low bit is 0 and `reqPc[63:42]` is neither all zeros nor all ones, the result is access violation.
- R3: When `spEnable` is 1 and `reqPc[42:41]` equals 2'b10 on a canonical address, the address maps directly to `rspPaddr = reqPc[39:0]` if `curMode` is kernel (0). For any other mode the result is access violation. When `spEnable` is 0, such an address goes to the translation buffer.
- R4: When the translation buffer misses, the result is miss and `rspPaddr` is 0. Every fault drives `rspPaddr` to 0.
- R5: On a translation-buffer hit with permission, `rspPaddr` is `{tlbPpn, reqPc[12:2], 2'b00}`.
- R6: On a hit where `tlbExecMask[curMode]` is 0, the result is access violation. The mode encoding is kernel 0, executive 1, supervisor 2, user 3.
- R7: On any fault, `capTag` takes `reqPc` and `capForm` takes `ptBase | (reqPc[42:13] << 3)`. Both hold their value when `reqMisspec` is 1 and on every request that does not fault.
- R8: `rspUncached` is 1 only on a non-faulting direct-mapped or hit response where paddr bit 39 is 1 and paddr bits 39:36 are not 4'hF, which is the internal register space.
- R9: `cntHit` counts non-faulting responses, `cntMiss` counts misses and `cntAcv` counts access violations. `cntAccess` always equals `cntHit + cntMiss`, including on misspeculated requests.
- R10: The response appears in the cycle after the request, with `rspValid` high for exactly that cycle per request. `tlbVpn` is `reqPc[42:13]` and `tlbAsn` is `curAsn`, both combinational. The result codes are none 0, access violation 1 and miss 2. Reset clears all registered outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Fetch request present this cycle |
| reqPc | input | 64 | Fetch virtual address |
| reqMisspec | input | 1 | Request is on a misspeculated path |
| curMode | input | 2 | Current privilege mode |
| spEnable | input | 1 | Enable for the kernel direct-mapped window |
| curAsn | input | 8 | Current address-space identifier |
| ptBase | input | 64 | Page-table base for the formatted fault address |
| tlbVpn | output | 30 | Page number driven to the translation buffer |
| tlbAsn | output | 8 | Address-space identifier driven to the buffer |
| tlbHit | input | 1 | Buffer hit |
| tlbPpn | input | 27 | Physical page number from the buffer |
| tlbExecMask | input | 4 | Execute permission per mode from the buffer |
| rspValid | output | 1 | Response valid |
| rspResult | output | 2 | Result code |
| rspPaddr | output | 40 | Physical address |
| rspUncached | output | 1 | Uncacheable space |
| capTag | output | 64 | Captured faulting address |
| capForm | output | 64 | Captured formatted page-table-entry address |
| cntHit | output | 16 | Hit counter |
| cntMiss | output | 16 | Miss counter |
| cntAcv | output | 16 | Access-violation counter |
| cntAccess | output | 16 | Hits plus misses |

## Verification
The bench checks the order of precedence among the checks. A privileged-code address that is also non-canonical must still resolve; a design that checked canonical form first would report an access violation. It drives the direct-mapped window with `spEnable` both on and off and in every mode. A design that ignored the mode would open kernel pages to user code, and one that ignored the enable would bypass the buffer. Execute masks that allow only some modes show whether the permission bit is indexed by the mode. A misspeculated fault must leave both capture registers stale, and a physical address in the internal register space must not be flagged uncacheable. Either mistake shows up as a mismatch against the bench's model on that cycle.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_ACV  = 2'd1,
    RES_MISS = 2'd2
  } ifxResult_e;

  typedef enum logic [1:0] {
    PATH_BYPASS = 2'd0,
    PATH_DIRECT = 2'd1,
    PATH_MAPPED = 2'd2,
    PATH_NONE   = 2'd3
  } ifxPath_e;

  typedef struct packed {
    logic       load;
    ifxResult_e result;
    ifxPath_e   path;
    logic       capture;
    logic       incHit;
    logic       incMiss;
    logic       incAcv;
  } ifxStrobe_t;

endpackage

// File: rtl/ifx_ctrl.sv
module ifx_ctrl
  import ifx_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int MODES   = 4,
  localparam int MODE_W = $clog2(MODES),
  localparam int HIGH_W = VA_W - VA_IMPL + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              pcPal,
  input  logic [HIGH_W-1:0] pcHigh,
  input  logic [1:0]        pcSpace,
  input  logic              reqMisspec,
  input  logic [MODE_W-1:0] curMode,
  input  logic              spEnable,
  input  logic              tlbHit,
  input  logic [MODES-1:0]  tlbExecMask,
  output ifxStrobe_t        strobe
);

  localparam logic [MODE_W-1:0] MODE_KERNEL = '0;

  logic canonical;
  logic inWindow;
  logic isKernel;
  logic execOk;

  assign canonical = (&pcHigh) || ~(|pcHigh);
  assign inWindow  = spEnable && (pcSpace == 2'b10);
  assign isKernel  = (curMode == MODE_KERNEL);
  assign execOk    = tlbExecMask[curMode];

  ifxResult_e res;
  ifxPath_e   path;

  always_comb begin
    res  = RES_NONE;
    path = PATH_NONE;
    if (pcPal) begin
      path = PATH_BYPASS;
    end else if (!canonical) begin
      res = RES_ACV;
    end else if (inWindow) begin
      if (isKernel) path = PATH_DIRECT;
      else          res  = RES_ACV;
    end else if (!tlbHit) begin
      res = RES_MISS;
    end else if (!execOk) begin
      res = RES_ACV;
    end else begin
      path = PATH_MAPPED;
    end
  end

  always_comb begin
    strobe.load    = reqValid;
    strobe.result  = res;
    strobe.path    = path;
    strobe.capture = reqValid && (res != RES_NONE) && !reqMisspec;
    strobe.incHit  = reqValid && (res == RES_NONE);
    strobe.incMiss = reqValid && (res == RES_MISS);
    strobe.incAcv  = reqValid && (res == RES_ACV);
  end

  // R9: at most one counter event per request
  a_r9_single_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.incHit, strobe.incMiss, strobe.incAcv}));

  // R1: a privileged-code address never faults
  a_r1_pal_no_fault: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && pcPal) |-> (strobe.incHit && !strobe.capture));

endmodule

// File: rtl/ifx_dpath.sv
module ifx_dpath
  import ifx_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL   = 43,
  parameter int PA_W      = 40,
  parameter int PAGE_W    = 13,
  parameter int CNT_W     = 16,
  parameter int IREG_BITS = 4,
  localparam int VPN_W    = VA_IMPL - PAGE_W,
  localparam int PPN_W    = PA_W - PAGE_W,
  localparam int NCNT     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ifxStrobe_t       strobe,
  input  logic [VA_W-1:0]  reqPc,
  input  logic [VA_W-1:0]  ptBase,
  input  logic [PPN_W-1:0] tlbPpn,
  output logic             rspValid,
  output logic [1:0]       rspResult,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             rspUncached,
  output logic [VA_W-1:0]  capTag,
  output logic [VA_W-1:0]  capForm,
  output logic [CNT_W-1:0] cntHit,
  output logic [CNT_W-1:0] cntMiss,
  output logic [CNT_W-1:0] cntAcv,
  output logic [CNT_W-1:0] cntAccess
);

  logic [PA_W-1:0]  nextPaddr;
  logic             nextUc;
  logic [VPN_W-1:0] vpn;
  logic [VA_W-1:0]  formAddr;

  assign vpn      = reqPc[VA_IMPL-1:PAGE_W];
  assign formAddr = ptBase | {{(VA_W-VPN_W-3){1'b0}}, vpn, 3'b000};

  always_comb begin
    unique case (strobe.path)
      PATH_BYPASS: nextPaddr = {reqPc[PA_W-1:2], 2'b00};
      PATH_DIRECT: nextPaddr = reqPc[PA_W-1:0];
      PATH_MAPPED: nextPaddr = {tlbPpn, reqPc[PAGE_W-1:2], 2'b00};
      default:     nextPaddr = '0;
    endcase
  end

  assign nextUc = ((strobe.path == PATH_DIRECT) || (strobe.path == PATH_MAPPED))
                  && nextPaddr[PA_W-1]
                  && !(&nextPaddr[PA_W-1:PA_W-IREG_BITS]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspResult   <= RES_NONE;
      rspPaddr    <= '0;
      rspUncached <= 1'b0;
    end else begin
      rspValid <= strobe.load;
      if (strobe.load) begin
        rspResult   <= strobe.result;
        rspPaddr    <= nextPaddr;
        rspUncached <= nextUc;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capTag  <= '0;
      capForm <= '0;
    end else if (strobe.capture) begin
      capTag  <= reqPc;
      capForm <= formAddr;
    end
  end

  logic [NCNT-1:0]  incVec;
  logic [CNT_W-1:0] cntVal [NCNT];

  assign incVec = {strobe.incAcv, strobe.incMiss, strobe.incHit};

  for (genvar g = 0; g < NCNT; g++) begin : gCnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cntVal[g] <= '0;
      else if (incVec[g]) cntVal[g] <= cntVal[g] + 1'b1;
    end
  end

  logic [CNT_W-1:0] accessReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                accessReg <= '0;
    else if (strobe.incHit || strobe.incMiss) accessReg <= accessReg + 1'b1;
  end

  assign cntHit    = cntVal[0];
  assign cntMiss   = cntVal[1];
  assign cntAcv    = cntVal[2];
  assign cntAccess = accessReg;

  // R1: privileged-code bypass address, one cycle later
  a_r1_bypass_addr: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && reqPc[0]) |=> (rspResult == RES_NONE &&
      rspPaddr == {$past(reqPc[PA_W-1:2]), 2'b00} && !rspUncached));

  // R4: faults carry a zero address
  a_r4_fault_zero_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspResult != RES_NONE) |-> (rspPaddr == '0));

  // R7: misspeculated requests leave the capture registers alone
  a_r7_capture_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.capture == 1'b0) |=> ($stable(capTag) && $stable(capForm)));

  // R8: uncacheable only on a successful response
  a_r8_uc_success: assert property (@(posedge clk) disable iff (!rstN)
    rspUncached |-> (rspResult == RES_NONE));

  // R9: access total tracks hits plus misses
  a_r9_access_sum: assert property (@(posedge clk) disable iff (!rstN)
    cntAccess == CNT_W'(cntHit + cntMiss));

  // R10: no response without a request
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !rspValid);

endmodule

// File: rtl/ifx_xlate.sv
module ifx_xlate
  import ifx_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL   = 43,
  parameter int PA_W      = 40,
  parameter int PAGE_W    = 13,
  parameter int ASN_W     = 8,
  parameter int MODES     = 4,
  parameter int CNT_W     = 16,
  parameter int IREG_BITS = 4,
  localparam int VPN_W    = VA_IMPL - PAGE_W,
  localparam int PPN_W    = PA_W - PAGE_W,
  localparam int MODE_W   = $clog2(MODES),
  localparam int HIGH_W   = VA_W - VA_IMPL + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqPc,
  input  logic              reqMisspec,
  input  logic [MODE_W-1:0] curMode,
  input  logic              spEnable,
  input  logic [ASN_W-1:0]  curAsn,
  input  logic [VA_W-1:0]   ptBase,
  output logic [VPN_W-1:0]  tlbVpn,
  output logic [ASN_W-1:0]  tlbAsn,
  input  logic              tlbHit,
  input  logic [PPN_W-1:0]  tlbPpn,
  input  logic [MODES-1:0]  tlbExecMask,
  output logic              rspValid,
  output logic [1:0]        rspResult,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspUncached,
  output logic [VA_W-1:0]   capTag,
  output logic [VA_W-1:0]   capForm,
  output logic [CNT_W-1:0]  cntHit,
  output logic [CNT_W-1:0]  cntMiss,
  output logic [CNT_W-1:0]  cntAcv,
  output logic [CNT_W-1:0]  cntAccess
);

  ifxStrobe_t strobe;

  assign tlbVpn = reqPc[VA_IMPL-1:PAGE_W];
  assign tlbAsn = curAsn;

  ifx_ctrl #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .MODES(MODES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .pcPal(reqPc[0]),
    .pcHigh(reqPc[VA_W-1:VA_IMPL-1]),
    .pcSpace(reqPc[VA_IMPL-1:VA_IMPL-2]),
    .reqMisspec(reqMisspec), .curMode(curMode), .spEnable(spEnable),
    .tlbHit(tlbHit), .tlbExecMask(tlbExecMask),
    .strobe(strobe)
  );

  ifx_dpath #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W), .PAGE_W(PAGE_W),
    .CNT_W(CNT_W), .IREG_BITS(IREG_BITS)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqPc(reqPc), .ptBase(ptBase), .tlbPpn(tlbPpn),
    .rspValid(rspValid), .rspResult(rspResult), .rspPaddr(rspPaddr),
    .rspUncached(rspUncached), .capTag(capTag), .capForm(capForm),
    .cntHit(cntHit), .cntMiss(cntMiss), .cntAcv(cntAcv), .cntAccess(cntAccess)
  );

endmodule

// File: tb/tb_ifx_xlate.sv
module tb_ifx_xlate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] reqPc = '0;
  logic        reqMisspec = 1'b0;
  logic [1:0]  curMode = '0;
  logic        spEnable = 1'b0;
  logic [7:0]  curAsn = '0;
  logic [63:0] ptBase = 64'h0000_0100_0000_0000;
  logic [29:0] tlbVpn;
  logic [7:0]  tlbAsn;
  logic        tlbHit;
  logic [26:0] tlbPpn;
  logic [3:0]  tlbExecMask;
  logic        rspValid;
  logic [1:0]  rspResult;
  logic [39:0] rspPaddr;
  logic        rspUncached;
  logic [63:0] capTag, capForm;
  logic [15:0] cntHit, cntMiss, cntAcv, cntAccess;

  always #5 clk = ~clk;

  ifx_xlate dut (.*);

  // Translation buffer contents, the environment of the block
  logic [29:0] tVpn  [4];
  logic [7:0]  tAsn  [4];
  logic        tGlb  [4];
  logic [26:0] tPpn  [4];
  logic [3:0]  tMask [4];

  initial begin
    tVpn[0] = 30'h10; tAsn[0] = 8'd5; tGlb[0] = 1'b0; tPpn[0] = 27'h0001234; tMask[0] = 4'b1111;
    tVpn[1] = 30'h20; tAsn[1] = 8'd5; tGlb[1] = 1'b0; tPpn[1] = 27'h4000010; tMask[1] = 4'b0001;
    tVpn[2] = 30'h30; tAsn[2] = 8'd0; tGlb[2] = 1'b1; tPpn[2] = 27'h7800000; tMask[2] = 4'b1000;
    tVpn[3] = 30'h40; tAsn[3] = 8'd7; tGlb[3] = 1'b0; tPpn[3] = 27'h4400002; tMask[3] = 4'b0110;
  end

  always_comb begin
    tlbHit = 1'b0; tlbPpn = '0; tlbExecMask = '0;
    for (int i = 0; i < 4; i++)
      if (!tlbHit && tVpn[i] == tlbVpn && (tGlb[i] || tAsn[i] == tlbAsn)) begin
        tlbHit = 1'b1; tlbPpn = tPpn[i]; tlbExecMask = tMask[i];
      end
  end

  // Behavioural reference model
  int unsigned compared = 0, mismatched = 0;
  string curReq = "R10";
  logic        eValid; logic [1:0] eRes; logic [39:0] ePaddr; logic eUc;
  logic [63:0] eTag, eForm;
  int unsigned eHit, eMiss, eAcv;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eValid = 0; eRes = 0; ePaddr = 0; eUc = 0; eTag = 0; eForm = 0;
      eHit = 0; eMiss = 0; eAcv = 0;
    end else begin
      eValid = reqValid;
      if (reqValid) begin
        logic [21:0] hi; logic found; logic [26:0] ppn; logic [3:0] msk;
        logic [29:0] vp; logic xlated;
        hi = reqPc[63:42]; vp = reqPc[42:13];
        found = 0; ppn = 0; msk = 0; xlated = 0;
        for (int i = 0; i < 4; i++)
          if (!found && tVpn[i] == vp && (tGlb[i] || tAsn[i] == curAsn)) begin
            found = 1; ppn = tPpn[i]; msk = tMask[i];
          end
        ePaddr = 0;
        if (reqPc[0]) begin eRes = 0; ePaddr = reqPc[39:0] & ~40'h3; end
        else if (!(hi == '0 || hi == '1)) eRes = 1;
        else if (spEnable && reqPc[42:41] == 2'b10) begin
          if (curMode == 0) begin eRes = 0; ePaddr = reqPc[39:0]; xlated = 1; end
          else eRes = 1;
        end
        else if (!found) eRes = 2;
        else if (!msk[curMode]) eRes = 1;
        else begin eRes = 0; ePaddr = {ppn, 13'h0} + (reqPc[12:0] & 13'h1ffc); xlated = 1; end
        eUc = xlated && ePaddr[39] && ePaddr[39:36] != 4'hF;
        if (eRes == 0) eHit++; else if (eRes == 2) eMiss++; else eAcv++;
        if (eRes != 0 && !reqMisspec) begin
          eTag = reqPc; eForm = ptBase | (64'(vp) << 3);
        end
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    chk("rspValid", 64'(rspValid), 64'(eValid));
    if (eValid) begin
      chk("rspResult", 64'(rspResult), 64'(eRes));
      chk("rspPaddr", 64'(rspPaddr), 64'(ePaddr));
      chk("rspUncached", 64'(rspUncached), 64'(eUc));
    end
    chk("capTag", capTag, eTag);
    chk("capForm", capForm, eForm);
    chk("cntHit", 64'(cntHit), 64'(eHit[15:0]));
    chk("cntMiss", 64'(cntMiss), 64'(eMiss[15:0]));
    chk("cntAcv", 64'(cntAcv), 64'(eAcv[15:0]));
    chk("cntAccess", 64'(cntAccess), 64'(16'(eHit + eMiss)));
  end

  task automatic req(logic [63:0] pc, logic [1:0] mode, logic misspec = 1'b0);
    reqValid = 1'b1; reqPc = pc; curMode = mode; reqMisspec = misspec;
    #1;
    chk("tlbVpn", 64'(tlbVpn), 64'(pc[42:13]));   // R10 lookup port
    chk("tlbAsn", 64'(tlbAsn), 64'(curAsn));
    @(negedge clk);
    reqValid = 1'b0; reqMisspec = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] va(logic [29:0] vpn, logic [12:0] ofs);
    return (64'(vpn) << 13) | 64'(ofs);
  endfunction

  localparam logic [63:0] SP_BASE = 64'hFFFF_FC00_0000_0000;
  bit finished = 0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    curAsn = 8'd5;
    idle(2);
    // R10: reset state of every registered output
    curReq = "R10";
    chk("rst rspValid", 64'(rspValid), 0);
    chk("rst capTag", capTag, 0);
    chk("rst cntHit", 64'(cntHit), 0);
    rstN = 1'b1;
    idle(2);

    curReq = "R1";  req(64'h0000_0012_3456_7893, 2'd3);
                    req(64'hFFFF_0000_8765_4321, 2'd0);   // non-canonical, bypass wins
    curReq = "R2";  req(64'h0001_0000_0002_0000, 2'd0);
                    req(64'hFFFE_0000_0000_0000, 2'd0);
    curReq = "R3";  spEnable = 1'b1;
                    req(SP_BASE | 64'h80_1234_5678, 2'd0);
                    req(SP_BASE | 64'h00_0000_4000, 2'd2);
                    req(SP_BASE | 64'h12_0000_0000, 2'd3);
                    spEnable = 1'b0;
                    req(SP_BASE | 64'h80_1234_5678, 2'd0);  // goes to buffer, misses
    curReq = "R4";  req(va(30'h55, 13'h100), 2'd0);
                    curAsn = 8'd6; req(va(30'h10, 13'h0), 2'd0); curAsn = 8'd5;
    curReq = "R5";  req(va(30'h10, 13'h1abf), 2'd3);
                    curAsn = 8'd9; req(va(30'h30, 13'h0024), 2'd3); curAsn = 8'd5;
    curReq = "R6";  for (int m = 0; m < 4; m++) req(va(30'h20, 13'h0010), 2'(m));
                    curAsn = 8'd7;
                    for (int m = 0; m < 4; m++) req(va(30'h40, 13'h0ff0), 2'(m));
                    curAsn = 8'd5;
    curReq = "R7";  ptBase = 64'h0000_0200_0000_0008;
                    req(va(30'h66, 13'h0), 2'd0, 1'b1);
                    req(64'h0400_0000_0000_0000, 2'd1, 1'b1);
                    req(va(30'h77, 13'h4), 2'd0, 1'b0);
                    req(va(30'h10, 13'h8), 2'd0, 1'b0);
    curReq = "R8";  spEnable = 1'b1;
                    req(SP_BASE | 64'hF0_0000_1000, 2'd0);
                    req(SP_BASE | 64'h70_0000_1000, 2'd0);
                    req(va(30'h20, 13'h0), 2'd0);
                    spEnable = 1'b0;
    curReq = "R9";  idle(3);
    for (int n = 0; n < 400; n++) begin
      logic [63:0] pcs [8];
      pcs[0] = va(30'h10, 13'($urandom));
      pcs[1] = va(30'h20, 13'($urandom));
      pcs[2] = va(30'h30, 13'($urandom));
      pcs[3] = va(30'h40, 13'($urandom));
      pcs[4] = SP_BASE | 64'($urandom);
      pcs[5] = {$urandom, $urandom};
      pcs[6] = va(30'($urandom), 13'($urandom));
      pcs[7] = {$urandom, $urandom} | 64'h1;
      curReq = "R9";
      spEnable = 1'($urandom);
      curAsn = 8'(4 + $urandom_range(0, 4));
      ptBase = {$urandom, $urandom};
      req(pcs[$urandom_range(0, 7)], 2'($urandom), 1'($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(3);
    finish_run();
  end

endmodule